// File: doc/BRIEF.md
# Mini UART Register Front-End

This block is the register face of a simplified UART. A 32-bit register bus reaches it through a 256-byte window. The bus has an address, a write strobe, a read strobe and data. Received bytes arrive on a valid/ready byte port and are stored in a small circular receive queue. Software drains the queue through the data register. A byte written to the data register leaves the block on a one-cycle transmit strobe. The transmit side is treated as instantly drained, so it always reports idle and empty.

The block holds two interrupt enables, one for receive and one for transmit. It drives a single interrupt line. It also builds several status words: an interrupt identify word, a line status word and an extended status word. The extended status word carries the live receive fill level. The remaining control registers are fixed constants or read as zero. Serial bit timing, baud generation and line control lie outside this block.

Top module: `mini_uart_regs`

## Requirements
- R1: After reset the interrupt output is low, `rx_ready_o` is high, and the interrupt-enable register at offset 0x44 reads 0xC0.
- R2: A write to offset 0x44 stores only `wdata_i[1:0]`, where bit 0 is the receive enable and bit 1 is the transmit enable. A read of 0x44 returns 0xC0 OR the stored enables.
- R3: `irq_o` is high when the transmit enable is set, or when the receive enable is set and the queue is non-empty. Offset 0x00 reads 1 when `irq_o` is high and 0 otherwise. The output follows any enable write, push, pop or clear by the next cycle.
- R4: Offset 0x48 reads 0xC0 OR a code in bits [2:1]. The code is 2'b10 when the queue is non-empty and 2'b01 when it is empty. Bit 0 is set when `irq_o` is low.
- R5: A write to 0x48 with bit 1 set empties the queue. A byte accepted in the same cycle survives as the only entry. A write to 0x48 with bit 1 clear has no effect.
- R6: A read of offset 0x40 returns the byte at the queue head and pops it. When the queue is empty, the read returns the stale byte at the head position and changes nothing.
- R7: Offset 0x54 reads 0x60, with bit 0 also set when the queue is non-empty.
- R8: Offset 0x64 reads 0x30E. When the queue is non-empty, bit 0 is also set and the fill count sits at bits [19:16].
- R9: Offset 0x04 reads 1 and offset 0x60 reads 3. Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and all unmapped offsets read 0. Writes to any of these offsets change nothing.
- R10: `rx_ready_o` is high exactly while the count is below DEPTH (default 8). Accepted bytes are read back in arrival order, with the storage position wrapping modulo DEPTH.
- R11: A write to 0x40 raises `tx_valid_o` in the following cycle, with `tx_data_o` equal to `wdata_i[7:0]`. The strobe lasts one cycle unless further writes follow.
- R12: When a byte is accepted in the same cycle as a data read of a non-empty queue, the count is unchanged and the read returns the old head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address within the window |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a read of 0x40 pops the queue |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Queue can accept a byte |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| irq_o | output | 1 | Interrupt line |

## Verification
Two operations can land in the same cycle: a byte arriving on the receive port, and a bus access that either pops the queue through a data read or clears it through an identify write. The random phase keeps the receive port busy while data reads and clears are issued. The directed phase forces a push with a pop on a non-empty queue, and a push with a clear. Each outcome is judged against a bench model of the queue: count, head and stored bytes. The model shows whether the byte survives and whether the popped value is the old head.

// File: rtl/mini_uart_pkg.sv
package mini_uart_pkg;
  // word indices (addr_i[7:2]); byte offset = index * 4
  localparam logic [5:0] W_SUMMARY = 6'h00;
  localparam logic [5:0] W_ENABLES = 6'h01;
  localparam logic [5:0] W_DATA    = 6'h10;
  localparam logic [5:0] W_IEN     = 6'h11;
  localparam logic [5:0] W_IDENT   = 6'h12;
  localparam logic [5:0] W_LSTAT   = 6'h15;
  localparam logic [5:0] W_CTRL    = 6'h18;
  localparam logic [5:0] W_XSTAT   = 6'h19;

  localparam logic [7:0]  FIFO_ON_BITS = 8'hC0;
  localparam logic [7:0]  TX_IDLE_BITS = 8'h60;
  localparam logic [31:0] XSTAT_BASE   = 32'h0000_030E;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
  } ien_t;
endpackage

// File: rtl/mini_uart_rx_fifo.sv
module mini_uart_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic          ready_o,
  output logic [DW-1:0] head_data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;
  logic [CW:0]   slot_sum;
  logic [PW-1:0] slot;
  logic [CW-1:0] cnt_base;

  assign ready_o     = (cnt_q < CW'(DEPTH));
  assign push_ok     = push_i && ready_o;
  assign pop_ok      = pop_i && (cnt_q != '0) && !clr_i;
  assign head_data_o = mem_q[head_q];
  assign count_o     = cnt_q;
  assign cnt_base    = clr_i ? '0 : cnt_q;

  always_comb begin
    slot_sum = {{(CW+1-PW){1'b0}}, head_q} + {1'b0, cnt_base};
    if (slot_sum >= (CW+1)'(DEPTH)) slot_sum = slot_sum - (CW+1)'(DEPTH);
    slot = slot_sum[PW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) mem_q[slot] <= push_data_i;
      if (pop_ok) head_q <= (head_q == PW'(DEPTH-1)) ? '0 : head_q + 1'b1;
      cnt_q <= cnt_base + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r10_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DEPTH)) |-> !ready_o);
  a_r12_push_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && pop_ok) |=> (cnt_q == $past(cnt_q)));
  a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !push_i) |=> (cnt_q == '0));
endmodule

// File: rtl/mini_uart_status.sv
module mini_uart_status
  import mini_uart_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  ien_t           ien_i,
  input  logic [CW-1:0]  count_i,
  output logic           irq_o,
  output logic [7:0]     ident_o,
  output logic [7:0]     lstat_o,
  output logic [31:0]    xstat_o
);
  logic nonempty, rx_pend;

  assign nonempty = (count_i != '0);
  assign rx_pend  = ien_i.rx_en && nonempty;
  assign irq_o    = rx_pend || ien_i.tx_en;

  // receive data outranks transmit in the identify code
  assign ident_o = FIFO_ON_BITS | (nonempty ? 8'h04 : 8'h02) | {7'b0, !irq_o};
  assign lstat_o = TX_IDLE_BITS | {7'b0, nonempty};

  always_comb begin
    xstat_o = XSTAT_BASE;
    if (nonempty) xstat_o = xstat_o | 32'h1 | (32'(count_i) << 16);
  end

  a_r3_tx_forces_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_i.tx_en |-> irq_o);
  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_i.tx_en && !nonempty) |-> !irq_o);
endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
  import mini_uart_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = PW + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        irq_o
);
  logic [5:0]    widx;
  ien_t          ien_q;
  logic          pop, clr;
  logic [7:0]    head_byte, ident, lstat;
  logic [31:0]   xstat;
  logic [CW-1:0] count;
  logic          tx_valid_q;
  logic [7:0]    tx_data_q;

  assign widx = addr_i[7:2];
  assign pop  = rd_i && (widx == W_DATA);
  assign clr  = wr_i && (widx == W_IDENT) && wdata_i[1];

  mini_uart_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_valid_i),
    .push_data_i (rx_data_i),
    .pop_i       (pop),
    .clr_i       (clr),
    .ready_o     (rx_ready_o),
    .head_data_o (head_byte),
    .count_o     (count)
  );

  mini_uart_status #(.CW(CW)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ien_i   (ien_q),
    .count_i (count),
    .irq_o   (irq_o),
    .ident_o (ident),
    .lstat_o (lstat),
    .xstat_o (xstat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q      <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (wr_i && widx == W_IEN) ien_q <= ien_t'(wdata_i[1:0]);
      tx_valid_q <= wr_i && (widx == W_DATA);
      if (wr_i && widx == W_DATA) tx_data_q <= wdata_i[7:0];
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  always_comb begin
    unique case (widx)
      W_SUMMARY: rdata_o = {31'b0, irq_o};
      W_ENABLES: rdata_o = 32'd1;
      W_DATA:    rdata_o = {24'b0, head_byte};
      W_IEN:     rdata_o = {24'b0, FIFO_ON_BITS | {6'b0, ien_q}};
      W_IDENT:   rdata_o = {24'b0, ident};
      W_LSTAT:   rdata_o = {24'b0, lstat};
      W_CTRL:    rdata_o = 32'd3;
      W_XSTAT:   rdata_o = xstat;
      default:   rdata_o = 32'b0;
    endcase
  end

  a_r11_tx_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(wr_i && widx == W_DATA));
  a_r2_ien_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && widx == W_IEN) |=> $stable(ien_q));
endmodule

// File: tb/mini_uart_regs_bench.sv
`timescale 1ns/1ps
module mini_uart_regs_bench;
  localparam int DEPTH = 8;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic        wr = 0, rd = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  rx_data = 0;
  logic        rx_valid = 0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        irq;

  always #4 clk = ~clk;

  mini_uart_regs #(.DEPTH(DEPTH)) u_mini_uart_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_mem [DEPTH];
  int m_head = 0, m_cnt = 0;
  logic [1:0] m_en = 0;
  logic m_tx = 0;
  logic [7:0] m_txb = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic m_irq();
    return m_en[1] || (m_en[0] && m_cnt != 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    case (a[7:2])
      6'h00: v = {31'b0, m_irq()};
      6'h01: v = 1;
      6'h10: v = {24'b0, m_mem[m_head]};
      6'h11: v = 32'hC0 | m_en;
      6'h12: v = 32'hC0 | ((m_cnt != 0) ? 4 : 2) | (m_irq() ? 0 : 1);
      6'h15: v = 32'h60 | ((m_cnt != 0) ? 1 : 0);
      6'h18: v = 3;
      6'h19: v = 32'h30E | ((m_cnt != 0) ? (1 | (m_cnt << 16)) : 0);
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a[7:2])
      6'h00: return "R3";
      6'h10: return "R6";
      6'h11: return "R2";
      6'h12: return "R4";
      6'h15: return "R7";
      6'h19: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] wd, input logic pv, input logic [7:0] pd);
    logic push, pop, clr;
    int slot;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = wd; rx_valid = pv; rx_data = pd;
    #1;
    check("R10", {31'b0, rx_ready}, {31'b0, (m_cnt < DEPTH)});
    check("R3", {31'b0, irq}, {31'b0, m_irq()});
    check("R11", {31'b0, tx_valid}, {31'b0, m_tx});
    if (m_tx) check("R11", {24'b0, tx_data}, {24'b0, m_txb});
    if (r) check(req_of(a), rdata, m_read(a));
    @(posedge clk);
    push = pv && (m_cnt < DEPTH);
    clr  = w && a[7:2] == 6'h12 && wd[1];
    pop  = r && a[7:2] == 6'h10 && m_cnt != 0 && !clr;
    slot = (m_head + (clr ? 0 : m_cnt)) % DEPTH;
    if (push) m_mem[slot] = pd;
    if (pop) m_head = (m_head + 1) % DEPTH;
    m_cnt = (clr ? 0 : m_cnt) + int'(push) - int'(pop);
    if (w && a[7:2] == 6'h11) m_en = wd[1:0];
    m_tx = w && a[7:2] == 6'h10;
    if (m_tx) m_txb = wd[7:0];
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] offs [14];
    offs = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54,
             8'h58, 8'h5C, 8'h60, 8'h64, 8'h68, 8'hA0};
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    step(0, 1, 8'h44, 0, 0, 0);
    check("R1", {31'b0, irq}, 0);
    check("R1", {31'b0, rx_ready}, 1);
    // R2 upper bits dropped
    step(1, 0, 8'h44, 32'hFFFF_FFFD, 0, 0);
    step(0, 1, 8'h44, 0, 0, 0);
    step(1, 0, 8'h44, 32'h0000_0001, 0, 0);
    // R10 fill to full, then blocked push
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 8'h64, 0, 1, 8'h10 + 8'(i));
    step(0, 1, 8'h48, 0, 0, 0);
    // R12 push with pop while full is blocked; drain one then push+pop
    step(0, 1, 8'h40, 0, 0, 0);
    step(0, 1, 8'h40, 0, 1, 8'hAA);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 8'h40, 0, 0, 0);
    // R6 empty read gives stale byte
    step(0, 1, 8'h40, 0, 0, 0);
    step(0, 1, 8'h54, 0, 0, 0);
    // R5 clear with concurrent push, then no-op write
    step(0, 0, 8'h00, 0, 1, 8'h51);
    step(0, 0, 8'h00, 0, 1, 8'h52);
    step(1, 0, 8'h48, 32'h2, 1, 8'h77);
    step(0, 1, 8'h64, 0, 0, 0);
    step(1, 0, 8'h48, 32'hFD, 0, 0);
    step(0, 1, 8'h40, 0, 0, 0);
    // R9 writes to fixed offsets ignored
    step(1, 0, 8'h5C, 32'hFFFF_FFFF, 0, 0);
    step(1, 0, 8'h04, 32'h0, 0, 0);
    step(0, 1, 8'h5C, 0, 0, 0);
    step(0, 1, 8'h04, 0, 0, 0);
    // R11 back-to-back and single transmit
    step(1, 0, 8'h40, 32'h1234_56A5, 0, 0);
    step(1, 0, 8'h40, 32'h0000_003C, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      int k;
      k = $urandom % 10;
      a = ($urandom % 8 == 0) ? 8'(($urandom % 64) << 2) : offs[$urandom % 14];
      if (k < 4)      step(0, 1, a, 0, ($urandom % 3) != 0, 8'($urandom));
      else if (k < 6) step(1, 0, a, $urandom, ($urandom % 2) != 0, 8'($urandom));
      else if (k < 8) step(0, 1, 8'h40, 0, ($urandom % 2) != 0, 8'($urandom));
      else            step(0, 0, 8'h00, 0, 1, 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule